// File: doc/BRIEF.md
# Two-Strike Watchdog Timer with Forced-Error Reset

This block is a memory-mapped watchdog peripheral. A register bus on the bus clock reaches it, and a separate oscillator clock drives its timeout counter. Software sets a 12-bit period value N and then enables counting. After that it must kick the watchdog before time runs out. One period lasts (N+1)·2^PRESC_LOG2 oscillator cycles, and PRESC_LOG2 is 20 by default. The first period that ends without a kick raises an interrupt. A second consecutive period without a kick asserts the reset request, which stays high until the block itself is reset.

Every register write except the kick is carried into the oscillator domain by a toggle handshake. The bus side holds the write stable while it is in flight and drops any further such write until the transfer is acknowledged. The kick has its own toggle path and never waits. Software can also request an immediate reset by forcing an error through a dedicated register. This path is active only while the error-control bit is zero.

Top module: `wdog_twostage`

## Requirements
- R1: After reset, `irq` and `rst_req` are 0 and every register reads 0.
- R2: Bit 0 of the control register (offset 0x00) enables counting. Once set, it cannot be cleared by a write and reads 1. Writing 0 before enabling leaves it 0.
- R3: The period register (offset 0x04) stores only bits 31:20 as N. Bits 19:0 are ignored and read 0.
- R4: A period write while enabled has no effect. The readback keeps the old value and the timeout still follows the old N.
- R5: (N+1)·2^PRESC_LOG2 oscillator cycles after the enable takes effect, an unkicked period ends. This raises `irq`, and bit 0 of offset 0x0C reads 1.
- R6: A second consecutive unkicked period asserts `rst_req`. It stays 1, and kicks do not clear it, until `rst` is applied.
- R7: Writing 1 to bit 0 of offset 0x0C is a kick. It restarts the period, clears the elapsed count and clears a pending interrupt. Writing 0 there has no effect.
- R8: Bits 11:0 of offset 0x08 report the number of whole 2^PRESC_LOG2-cycle units elapsed in the current period. Any write there zeroes the count and restarts the period.
- R9: With bit 0 of the error-control register (offset 0x10) at 0, writing 1 to bit 0 of the force register (offset 0x14) asserts `rst_req`, whether or not counting is enabled. With the control bit at 1, or with a 0 written, the force write does nothing. The force register reads 0.
- R10: A write to any register other than 0x0C reaches the oscillator domain within four oscillator cycles. Until that write is acknowledged back on the bus side, any further write to those registers is dropped.
- R11: Offsets that are not mapped read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register bus clock |
| clk_osc | input | 1 | Oscillator clock for the timeout counter |
| rst | input | 1 | Synchronous active-high block reset (bus clock; resynchronised to the oscillator clock) |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, one bus cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| irq | output | 1 | First-overflow interrupt, bus clock domain |
| rst_req | output | 1 | Sticky reset request, oscillator clock domain |

## Verification
Read data is combinational, so every register read is sampled in the same bus cycle the address is driven. Timeout results are measured in oscillator cycles from the bus write that enabled counting. `irq` is due within about (N+1)·2^P+6 oscillator cycles, and `rst_req` within 2·(N+1)·2^P+6. Each check looks for the output still low two cycles before the nominal edge and already high eight to ten cycles after it. That window covers the synchronizer stages in both directions. Register writes that cross domains are followed by a wait of twelve oscillator cycles before the next write or readback. The only exception is the write-drop case, which issues two writes back to back on purpose.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W     = 32;
    localparam int PERIOD_W   = 12;
    localparam int PERIOD_LSB = 20;

    // byte offsets decoded by software
    localparam logic [7:0] OFS_CTRL    = 8'h00;
    localparam logic [7:0] OFS_PERIOD  = 8'h04;
    localparam logic [7:0] OFS_ELAPSED = 8'h08;
    localparam logic [7:0] OFS_KICK    = 8'h0C;
    localparam logic [7:0] OFS_ERRCTL  = 8'h10;
    localparam logic [7:0] OFS_FORCE   = 8'h14;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_PERIOD,
        SEL_ELAPSED,
        SEL_KICK,
        SEL_ERRCTL,
        SEL_FORCE
    } reg_sel_e;

    // command carried from the bus domain into the oscillator domain
    typedef struct packed {
        reg_sel_e              sel;
        logic [PERIOD_W-1:0]   payload;
    } xfer_cmd_t;

    function automatic reg_sel_e decode_sel(input logic [7:0] a);
        reg_sel_e s;
        case (a)
            OFS_CTRL:    s = SEL_CTRL;
            OFS_PERIOD:  s = SEL_PERIOD;
            OFS_ELAPSED: s = SEL_ELAPSED;
            OFS_KICK:    s = SEL_KICK;
            OFS_ERRCTL:  s = SEL_ERRCTL;
            OFS_FORCE:   s = SEL_FORCE;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

    // true for registers whose writes go through the handshake
    function automatic logic is_crossing(input reg_sel_e s);
        return (s == SEL_CTRL) || (s == SEL_PERIOD) || (s == SEL_ELAPSED) ||
               (s == SEL_ERRCTL) || (s == SEL_FORCE);
    endfunction

    function automatic logic [PERIOD_W-1:0] pack_payload(
        input reg_sel_e            s,
        input logic [PERIOD_W-1:0] hi_field,
        input logic                bit0
    );
        logic [PERIOD_W-1:0] p;
        if (s == SEL_PERIOD) p = hi_field;
        else                 p = {{(PERIOD_W-1){1'b0}}, bit0};
        return p;
    endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        chain[0] <= d;
        for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/wdt_bus_side.sv
module wdt_bus_side
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                we,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output xfer_cmd_t           cmd,
    output logic                req_tgl,
    input  logic                ack_tgl_s,
    output logic                kick_tgl,
    input  logic                irq_s,
    input  logic                snap_tgl_s,
    input  logic [PERIOD_W-1:0] snap_data,
    output logic                irq
);

    logic                hi_zero;
    logic [7:0]          a8;
    reg_sel_e            sel;
    logic                busy;
    logic                accept;
    logic                sh_en;
    logic                sh_errctl;
    logic [PERIOD_W-1:0] sh_period;
    logic [PERIOD_W-1:0] elapsed_q;
    logic                snap_seen;
    logic                unused_wbits;

    assign a8 = addr[7:0];

    generate
        if (ADDR_W > 8) begin : g_wide_addr
            assign hi_zero = (addr[ADDR_W-1:8] == '0);
        end else begin : g_byte_addr
            assign hi_zero = 1'b1;
        end
    endgenerate

    assign sel          = hi_zero ? decode_sel(a8) : SEL_NONE;
    assign busy         = (req_tgl != ack_tgl_s);
    assign accept       = we && is_crossing(sel) && !busy;
    assign unused_wbits = ^wdata[PERIOD_LSB-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_en     <= 1'b0;
            sh_errctl <= 1'b0;
            sh_period <= '0;
            req_tgl   <= 1'b0;
            kick_tgl  <= 1'b0;
            cmd       <= '{sel: SEL_NONE, payload: '0};
            snap_seen <= 1'b0;
            elapsed_q <= '0;
        end else begin
            if (accept) begin
                cmd     <= '{sel: sel,
                             payload: pack_payload(sel, wdata[DATA_W-1:PERIOD_LSB], wdata[0])};
                req_tgl <= ~req_tgl;
                case (sel)
                    SEL_CTRL:   sh_en     <= sh_en | wdata[0];
                    SEL_PERIOD: if (!sh_en) sh_period <= wdata[DATA_W-1:PERIOD_LSB];
                    SEL_ERRCTL: sh_errctl <= wdata[0];
                    default: ;
                endcase
            end
            if (we && (sel == SEL_KICK) && wdata[0]) begin
                kick_tgl <= ~kick_tgl;
            end
            snap_seen <= snap_tgl_s;
            if (snap_tgl_s != snap_seen) begin
                elapsed_q <= snap_data;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL:    rdata[0] = sh_en;
            SEL_PERIOD:  rdata[DATA_W-1:PERIOD_LSB] = sh_period;
            SEL_ELAPSED: rdata[PERIOD_W-1:0] = elapsed_q;
            SEL_KICK:    rdata[0] = irq_s;
            SEL_ERRCTL:  rdata[0] = sh_errctl;
            default:     rdata = '0;
        endcase
    end

    assign irq = irq_s;

    // R10
    drop_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (we && busy && is_crossing(sel)) |=> ($stable(cmd) && $stable(req_tgl)));

    // R2
    enable_sticky_bus_chk: assert property (@(posedge clk) disable iff (rst)
        sh_en |=> sh_en);

    // R4
    period_frozen_bus_chk: assert property (@(posedge clk) disable iff (rst)
        sh_en |=> $stable(sh_period));

endmodule

// File: rtl/wdt_osc_core.sv
module wdt_osc_core
    import wdt_pkg::*;
#(
    parameter int PRESC_LOG2 = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  xfer_cmd_t           cmd,
    input  logic                req_tgl_s,
    output logic                ack_tgl,
    input  logic                kick_tgl_s,
    output logic                irq_flag,
    output logic [PERIOD_W-1:0] snap_data,
    output logic                snap_tgl,
    output logic                rst_req
);

    logic                  seen;
    logic                  kick_d;
    logic                  apply;
    logic                  kick_pulse;
    logic                  en;
    logic                  errctl;
    logic [PERIOD_W-1:0]   period;
    logic [PRESC_LOG2-1:0] presc;
    logic [PERIOD_W-1:0]   units;
    logic                  armed;
    logic                  tick;
    logic                  wrap;
    logic                  force_hit;
    logic                  clear_cnt;

    assign apply      = (req_tgl_s != seen);
    assign kick_pulse = (kick_tgl_s != kick_d);
    assign tick       = en && (&presc);
    assign wrap       = tick && (units == period);
    assign force_hit  = apply && (cmd.sel == SEL_FORCE) && cmd.payload[0] && !errctl;
    assign clear_cnt  = kick_pulse || (apply && (cmd.sel == SEL_ELAPSED));

    // command application
    always_ff @(posedge clk) begin
        if (rst) begin
            seen   <= 1'b0;
            en     <= 1'b0;
            errctl <= 1'b0;
            period <= '0;
        end else begin
            seen <= req_tgl_s;
            if (apply) begin
                case (cmd.sel)
                    SEL_CTRL:   en     <= en | cmd.payload[0];
                    SEL_PERIOD: if (!en) period <= cmd.payload;
                    SEL_ERRCTL: errctl <= cmd.payload[0];
                    default: ;
                endcase
            end
        end
    end

    // prescaler and unit counter
    always_ff @(posedge clk) begin
        if (rst) begin
            kick_d <= 1'b0;
            presc  <= '0;
            units  <= '0;
        end else begin
            kick_d <= kick_tgl_s;
            if (clear_cnt) begin
                presc <= '0;
                units <= '0;
            end else if (en) begin
                presc <= presc + 1'b1;
                if (tick) begin
                    units <= wrap ? '0 : units + 1'b1;
                end
            end
        end
    end

    // overflow tracking and reset generation
    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            if (kick_pulse) begin
                armed <= 1'b0;
            end else if (wrap) begin
                if (armed) rst_req <= 1'b1;
                else       armed   <= 1'b1;
            end
            if (force_hit) begin
                rst_req <= 1'b1;
            end
        end
    end

    // elapsed snapshot for the bus side
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_data <= '0;
            snap_tgl  <= 1'b0;
        end else if (units != snap_data) begin
            snap_data <= units;
            snap_tgl  <= ~snap_tgl;
        end
    end

    assign ack_tgl  = seen;
    assign irq_flag = armed;

    // R6
    rst_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> rst_req);

    // R6
    rst_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> ($past(armed) || $past(force_hit)));

    // R2
    enable_sticky_osc_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> en);

    // R4
    period_frozen_osc_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> $stable(period));

    // R5
    unit_bound_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (units <= period));

endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
    import wdt_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PRESC_LOG2  = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_bus,
    input  logic              clk_osc,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              rst_req
);

    logic                rst_osc;
    xfer_cmd_t           cmd;
    logic                req_tgl;
    logic                req_tgl_s;
    logic                ack_tgl;
    logic                ack_tgl_s;
    logic                kick_tgl;
    logic                kick_tgl_s;
    logic                irq_flag;
    logic                irq_s;
    logic                snap_tgl;
    logic                snap_tgl_s;
    logic [PERIOD_W-1:0] snap_data;

    // oscillator-domain crossings
    wdt_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_sync_rst (
        .clk(clk_osc), .d(rst), .q(rst_osc));
    wdt_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_sync_req (
        .clk(clk_osc), .d(req_tgl), .q(req_tgl_s));
    wdt_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_sync_kick (
        .clk(clk_osc), .d(kick_tgl), .q(kick_tgl_s));

    // bus-domain crossings
    wdt_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_sync_ack (
        .clk(clk_bus), .d(ack_tgl), .q(ack_tgl_s));
    wdt_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_sync_irq (
        .clk(clk_bus), .d(irq_flag), .q(irq_s));
    wdt_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_sync_snap (
        .clk(clk_bus), .d(snap_tgl), .q(snap_tgl_s));

    wdt_bus_side #(.ADDR_W(ADDR_W)) i_bus_side (
        .clk        (clk_bus),
        .rst        (rst),
        .addr       (bus_addr),
        .we         (bus_we),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata),
        .cmd        (cmd),
        .req_tgl    (req_tgl),
        .ack_tgl_s  (ack_tgl_s),
        .kick_tgl   (kick_tgl),
        .irq_s      (irq_s),
        .snap_tgl_s (snap_tgl_s),
        .snap_data  (snap_data),
        .irq        (irq)
    );

    wdt_osc_core #(.PRESC_LOG2(PRESC_LOG2)) i_osc_core (
        .clk        (clk_osc),
        .rst        (rst_osc),
        .cmd        (cmd),
        .req_tgl_s  (req_tgl_s),
        .ack_tgl    (ack_tgl),
        .kick_tgl_s (kick_tgl_s),
        .irq_flag   (irq_flag),
        .snap_data  (snap_data),
        .snap_tgl   (snap_tgl),
        .rst_req    (rst_req)
    );

endmodule

// File: tb/test_wdog_twostage.sv
module test_wdog_twostage;

    localparam int CLK_PERIOD = 10;
    localparam int OSC_PERIOD = 14;
    localparam int PRESC      = 4;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_PER  = 8'h04;
    localparam logic [7:0] A_ELP  = 8'h08;
    localparam logic [7:0] A_KICK = 8'h0C;
    localparam logic [7:0] A_ECTL = 8'h10;
    localparam logic [7:0] A_FRC  = 8'h14;

    logic        clk_bus = 1'b0;
    logic        clk_osc = 1'b0;
    logic        rst     = 1'b1;
    logic [7:0]  bus_addr  = '0;
    logic        bus_we    = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rst_req;

    int unsigned osc_ticks = 0;
    int n_checks = 0;
    int n_err    = 0;

    always #(CLK_PERIOD/2) clk_bus = ~clk_bus;
    always #(OSC_PERIOD/2) clk_osc = ~clk_osc;
    always @(posedge clk_osc) osc_ticks <= osc_ticks + 1;

    wdog_twostage #(.ADDR_W(8), .PRESC_LOG2(PRESC), .SYNC_STAGES(2)) i_wdog_twostage (
        .clk_bus(clk_bus), .clk_osc(clk_osc), .rst(rst),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req));

    function automatic logic [31:0] exp_period_rd(input logic [31:0] d);
        return {d[31:20], 20'h0};
    endfunction

    function automatic int unsigned period_len(input int unsigned n);
        return (n + 1) << PRESC;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk_bus);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk_bus);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk_bus);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_osc_to(input int unsigned t);
        while (osc_ticks < t) @(posedge clk_osc);
        @(negedge clk_bus);
    endtask

    task automatic settle();
        wait_osc_to(osc_ticks + 12);
    endtask

    task automatic do_reset();
        @(negedge clk_bus);
        rst = 1'b1;
        repeat (12) @(negedge clk_bus);
        rst = 1'b0;
        settle();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog R1..: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int unsigned s, t, k, n;
        void'($urandom(32'h00C0FFEE));

        // ---- R1 reset state
        do_reset();
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 rst_req", {31'b0, rst_req}, 32'h0);
        bus_read(A_CTRL, rd); check("R1 ctrl", rd, 32'h0);
        bus_read(A_PER,  rd); check("R1 period", rd, 32'h0);
        bus_read(A_ELP,  rd); check("R1 elapsed", rd, 32'h0);
        bus_read(A_KICK, rd); check("R1 status", rd, 32'h0);
        bus_read(A_ECTL, rd); check("R1 errctl", rd, 32'h0);

        // ---- R2 writing 0 before enabling
        bus_write(A_CTRL, 32'h0); settle();
        bus_read(A_CTRL, rd); check("R2 zero write", rd, 32'h0);

        // ---- R11 unmapped offsets
        bus_write(8'h18, 32'hFFFF_FFFF); settle();
        bus_write(8'h40, 32'hFFFF_FFFF); settle();
        bus_read(8'h18, rd); check("R11 unmapped read", rd, 32'h0);
        bus_read(A_CTRL, rd); check("R11 ctrl untouched", rd, 32'h0);
        bus_read(A_PER, rd);  check("R11 period untouched", rd, 32'h0);

        // ---- R3 / R9 random register patterns
        for (int i = 0; i < 8; i++) begin
            logic [31:0] d1, d2;
            d1 = $urandom; d2 = $urandom;
            bus_write(A_PER, d1); settle();
            bus_read(A_PER, rd); check("R3 period field", rd, exp_period_rd(d1));
            bus_write(A_ECTL, d2); settle();
            bus_read(A_ECTL, rd); check("R9 errctl field", rd, {31'b0, d2[0]});
        end
        bus_write(A_PER, 32'h0030_0ABC); settle();
        bus_read(A_PER, rd); check("R3 low bits", rd, 32'h0030_0000);

        // ---- R10 back-to-back write dropped
        do_reset();
        bus_write(A_PER, 32'h0010_0000);
        bus_write(A_PER, 32'h0050_0000);
        settle();
        bus_read(A_PER, rd); check("R10 second write dropped", rd, 32'h0010_0000);
        bus_write(A_PER, 32'h0050_0000); settle();
        bus_read(A_PER, rd); check("R10 write after ack", rd, 32'h0050_0000);

        // ---- R2 R4 R5 R6 R8 timeout sequence, N=5
        bus_write(A_CTRL, 32'h1); s = osc_ticks;
        t = period_len(5);
        wait_osc_to(s + 12); bus_write(A_CTRL, 32'h0);
        wait_osc_to(s + 24); bus_write(A_PER, 32'h0070_0000);
        wait_osc_to(s + 42);
        bus_read(A_ELP, rd);  check("R8 elapsed units", rd, 32'd2);
        bus_read(A_CTRL, rd); check("R2 enable sticky", rd, 32'h1);
        bus_read(A_PER, rd);  check("R4 period frozen", rd, 32'h0050_0000);
        wait_osc_to(s + t - 2);
        check("R5 irq early", {31'b0, irq}, 32'h0);
        bus_read(A_KICK, rd); check("R5 status early", rd, 32'h0);
        wait_osc_to(s + t + 10);
        check("R5 irq due", {31'b0, irq}, 32'h1);
        bus_read(A_KICK, rd); check("R5 status due", rd, 32'h1);
        wait_osc_to(s + 2*t - 2);
        check("R6 rst_req early", {31'b0, rst_req}, 32'h0);
        wait_osc_to(s + 2*t + 8);
        check("R6 rst_req due", {31'b0, rst_req}, 32'h1);
        bus_write(A_KICK, 32'h1);
        wait_osc_to(osc_ticks + 30);
        check("R6 rst_req sticky", {31'b0, rst_req}, 32'h1);
        do_reset();
        check("R6 cleared by rst", {31'b0, rst_req}, 32'h0);

        // ---- R8 elapsed clear, N=3
        bus_write(A_PER, 32'h0030_0000); settle();
        bus_write(A_CTRL, 32'h1); s = osc_ticks;
        t = period_len(3);
        wait_osc_to(s + 42);
        bus_read(A_ELP, rd); check("R8 elapsed before clear", rd, 32'd2);
        bus_write(A_ELP, 32'h0); k = osc_ticks;
        wait_osc_to(k + 12);
        bus_read(A_ELP, rd); check("R8 elapsed cleared", rd, 32'd0);
        wait_osc_to(s + t + 10);
        check("R8 period restarted", {31'b0, irq}, 32'h0);
        wait_osc_to(k + t + 10);
        check("R8 irq after restart", {31'b0, irq}, 32'h1);

        // ---- R7 kick clears pending irq, zero write ignored, N=2
        do_reset();
        bus_write(A_PER, 32'h0020_0000); settle();
        bus_write(A_CTRL, 32'h1); s = osc_ticks;
        t = period_len(2);
        wait_osc_to(s + t + 10);
        check("R7 irq pending", {31'b0, irq}, 32'h1);
        bus_write(A_KICK, 32'h0);
        wait_osc_to(osc_ticks + 10);
        check("R7 zero write ignored", {31'b0, irq}, 32'h1);
        bus_write(A_KICK, 32'h1); k = osc_ticks;
        wait_osc_to(k + 10);
        check("R7 kick clears irq", {31'b0, irq}, 32'h0);
        bus_read(A_KICK, rd); check("R7 status cleared", rd, 32'h0);
        wait_osc_to(s + 2*t + 10);
        check("R7 reset averted", {31'b0, rst_req}, 32'h0);
        wait_osc_to(k + t + 10);
        check("R7 irq after kick period", {31'b0, irq}, 32'h1);
        wait_osc_to(k + 2*t + 10);
        check("R7 rst after kick periods", {31'b0, rst_req}, 32'h1);

        // ---- R7 random kick intervals
        for (int trial = 0; trial < 3; trial++) begin
            do_reset();
            n = $urandom_range(1, 3);
            t = period_len(n);
            bus_write(A_PER, {n[11:0], 20'h0}); settle();
            bus_write(A_CTRL, 32'h1); k = osc_ticks;
            for (int j = 0; j < 6; j++) begin
                wait_osc_to(k + $urandom_range(t/2, t - 12));
                bus_write(A_KICK, 32'h1); k = osc_ticks;
            end
            check("R7 kicked irq", {31'b0, irq}, 32'h0);
            check("R7 kicked rst_req", {31'b0, rst_req}, 32'h0);
            wait_osc_to(k + t + 10);
            check("R5 irq after last kick", {31'b0, irq}, 32'h1);
            wait_osc_to(k + 2*t + 10);
            check("R6 rst after last kick", {31'b0, rst_req}, 32'h1);
        end

        // ---- R9 forced error path
        do_reset();
        bus_write(A_FRC, 32'h0); settle();
        check("R9 force zero", {31'b0, rst_req}, 32'h0);
        bus_write(A_FRC, 32'h1); settle();
        check("R9 force fires", {31'b0, rst_req}, 32'h1);
        do_reset();
        bus_write(A_ECTL, 32'h1); settle();
        bus_write(A_FRC, 32'h1);
        wait_osc_to(osc_ticks + 20);
        check("R9 force masked", {31'b0, rst_req}, 32'h0);
        bus_read(A_FRC, rd); check("R9 force reads 0", rd, 32'h0);
        bus_write(A_ECTL, 32'h0); settle();
        bus_write(A_FRC, 32'h1); settle();
        check("R9 force after unmask", {31'b0, rst_req}, 32'h1);

        summary();
        $finish;
    end

endmodule